// File: doc/BRIEF.md
# Byte-Stream DMA Transfer Engine

This block copies a programmed number of bytes from a device port into memory without any processor involvement. Software presents a start address and a byte count, then pulses a start input. The engine spends a fixed setup period, then moves one byte per transfer. Each transfer first reads a byte from the device and then writes that byte to memory at the current address.

After every byte the address goes up by one and the remaining count goes down by one. When the count is exhausted, a done flag rises and stays high until the next accepted start. An interrupt line pulses for a single cycle at the same moment. The device can hold off a transfer by keeping its valid signal low during the read cycle. With the default 20-cycle setup and a 500-byte job, done rises 1020 cycles after start when the device never stalls.

Top module: `dma_byte_engine`

## Requirements
- R1: After a start is accepted, busy_o is high, and neither dev_rd_o nor mem_we_o is asserted for the first SETUP_CYCLES (default 20) cycles.
- R2: Each byte uses one read cycle (dev_rd_o high) and then one write cycle. In the write cycle, mem_we_o is high for exactly one cycle and mem_data_o carries the byte sampled from dev_data_i at the end of the read cycle.
- R3: The k-th byte of a job (k counted from 0) is written to mem_addr_o = start address + k, modulo 2^ADDR_W.
- R4: A job with count N performs exactly N memory writes. With no stalls, done_o rises SETUP_CYCLES + 2*N cycles after the clock edge that accepts the start.
- R5: A start with a count of zero performs no memory write. done_o rises SETUP_CYCLES cycles after the accepting edge.
- R6: If dev_valid_i is low during a read cycle, the engine stays in that read cycle without advancing the address or the count. Each such cycle adds one cycle to the completion time.
- R7: done_o stays high until the next accepted start and is low in the cycle after that start. irq_o is high for exactly one cycle, in the first cycle that done_o is high.
- R8: A start_i pulse while busy_o is high is ignored. The running job's addresses, data, write count and completion time are unchanged.
- R9: While reset is asserted and after its release, busy_o, done_o, irq_o, dev_rd_o and mem_we_o are all low until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| start_addr_i | input | ADDR_W | First memory address of the job |
| byte_count_i | input | CNT_W | Number of bytes to move |
| dev_valid_i | input | 1 | Device has a byte ready in the read cycle |
| dev_data_i | input | DATA_W | Device byte |
| dev_rd_o | output | 1 | Read cycle in progress |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | DATA_W | Memory write data |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Last job complete; held until the next start |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
Cycles are counted from the clock edge that accepts a start:
- Setup occupies cycles 0 to 19.
- The first read strobe appears in cycle 20.
- Each byte's write strobe follows its accepted read by one cycle.
- done_o and irq_o appear in cycle 20 + 2N + S, where S is the number of stall cycles the bench injected.

The bench counts cycles from the accepting edge and samples every output on the falling edge. It checks the setup silence, every write's address and data, and the exact cycle in which done and irq appear, against that formula. It also checks that irq_o has dropped one cycle later, that done_o is still held at that point, and that done_o has cleared in the cycle after the next accepted start.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } dma_state_e;
endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_eng_pkg::*;
#(
  parameter int SETUP_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       dev_valid_i,
  input  logic       cnt_zero_i,
  input  logic       cnt_last_i,
  output dma_state_e state_o,
  output logic       load_o,
  output logic       step_o,
  output logic       capture_o,
  output logic       done_o,
  output logic       irq_o
);
  localparam int TMR_W = $clog2(SETUP_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SETUP_CYCLES - 1);

  dma_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             done_q, done_d, irq_q, irq_d;
  logic             finish_c;

  always_comb begin
    state_d  = state_q;
    finish_c = 1'b0;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_SETUP;
      ST_SETUP: if (tmr_q == TMR_LAST) begin
                  if (cnt_zero_i) begin
                    state_d  = ST_IDLE;
                    finish_c = 1'b1;
                  end else begin
                    state_d = ST_READ;
                  end
                end
      ST_READ:  if (dev_valid_i) state_d = ST_WRITE;
      ST_WRITE: if (cnt_last_i) begin
                  state_d  = ST_IDLE;
                  finish_c = 1'b1;
                end else begin
                  state_d = ST_READ;
                end
      default:  state_d = ST_IDLE;
    endcase
  end

  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign step_o    = (state_q == ST_WRITE);
  assign capture_o = (state_q == ST_READ) && dev_valid_i;

  always_comb begin
    tmr_d = tmr_q;
    if (load_o) tmr_d = '0;
    else if (state_q == ST_SETUP) tmr_d = tmr_q + 1'b1;
  end

  always_comb begin
    done_d = done_q;
    if (finish_c) done_d = 1'b1;
    else if (load_o) done_d = 1'b0;
    irq_d = finish_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
  assign irq_o   = irq_q;

  // Independent count of consecutive setup cycles, used only by the check below.
  logic [TMR_W:0] chk_setup_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_setup_len <= '0;
    else if (state_q == ST_SETUP) chk_setup_len <= chk_setup_len + 1'b1;
    else chk_setup_len <= '0;
  end

  a_r1_setup_span: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && state_d != ST_SETUP) |-> (int'(chk_setup_len) == SETUP_CYCLES - 1));
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_o) |=> done_o);
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i) |=> (state_q != ST_SETUP || $past(state_q) == ST_SETUP));
endmodule

// File: rtl/dma_addr_path.sv
module dma_addr_path #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              cnt_zero_o,
  output logic              cnt_last_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      addr_d = addr_i;
      cnt_d  = cnt_i;
    end else if (step_i) begin
      addr_d = addr_q + 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
    data_d = capture_i ? data_i : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      data_q <= data_d;
    end
  end

  assign addr_o     = addr_q;
  assign data_o     = data_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign cnt_last_o = (cnt_q == CNT_ONE);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (addr_q == $past(addr_q) + 1'b1));
  a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> ($stable(addr_q) && $stable(cnt_q)));
endmodule

// File: rtl/dma_byte_engine.sv
module dma_byte_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int CNT_W        = 16,
  parameter int DATA_W       = 8,
  parameter int SETUP_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  input  logic              dev_valid_i,
  input  logic [DATA_W-1:0] dev_data_i,
  output logic              dev_rd_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o
);
  dma_state_e state;
  logic load, step, capture, cnt_zero, cnt_last;

  dma_seq_fsm #(.SETUP_CYCLES(SETUP_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dev_valid_i(dev_valid_i),
    .cnt_zero_i (cnt_zero),
    .cnt_last_i (cnt_last),
    .state_o    (state),
    .load_o     (load),
    .step_o     (step),
    .capture_o  (capture),
    .done_o     (done_o),
    .irq_o      (irq_o)
  );

  dma_addr_path #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .step_i    (step),
    .capture_i (capture),
    .addr_i    (start_addr_i),
    .cnt_i     (byte_count_i),
    .data_i    (dev_data_i),
    .addr_o    (mem_addr_o),
    .data_o    (mem_data_o),
    .cnt_zero_o(cnt_zero),
    .cnt_last_o(cnt_last)
  );

  assign dev_rd_o = (state == ST_READ);
  assign mem_we_o = (state == ST_WRITE);
  assign busy_o   = (state != ST_IDLE);

  a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(dev_rd_o && dev_valid_i));
  a_r2_data_from_device: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_data_o == $past(dev_data_i)));
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);
endmodule

// File: tb/dma_byte_engine_tb.sv
module dma_byte_engine_tb_top;
  localparam int SETUP = 20;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] cnt;
    logic [3:0]  stall_k;
    logic [15:0] intr_c;
  } job_t;

  // Job vectors: start address, count, stall period (0 = none), cycle of an intruding start (0 = none)
  localparam job_t [0:5] JOBS = '{
    '{32'h0000_1000, 16'd500, 4'd0, 16'd0},
    '{32'hFFFF_FFFE, 16'd3,   4'd0, 16'd0},
    '{32'h0000_2000, 16'd6,   4'd3, 16'd0},
    '{32'h0000_3000, 16'd4,   4'd0, 16'd10},
    '{32'h0000_4000, 16'd4,   4'd2, 16'd23},
    '{32'h0000_5000, 16'd0,   4'd0, 16'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] start_addr_i;
  logic [15:0] byte_count_i;
  logic        dev_valid_i;
  logic [7:0]  dev_data_i;
  logic        dev_rd_o, mem_we_o, busy_o, done_o, irq_o;
  logic [31:0] mem_addr_o;
  logic [7:0]  mem_data_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_byte_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_count_i(byte_count_i), .dev_valid_i(dev_valid_i), .dev_data_i(dev_data_i),
    .dev_rd_o(dev_rd_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o), .busy_o(busy_o), .done_o(done_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] pattern(input int seed, input int i);
    return 8'((i * 37) + (seed * 11) + 5);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_job(input int idx);
    job_t j = JOBS[idx];
    int c = 0, wr = 0, rd = 0, stalls = 0, aerr = 0, derr = 0, setup_bad = 0, done_c = -1;
    bit stalled = 1'b0;
    bit irq_at_done = 1'b0;
    @(negedge clk);
    start_i = 1'b1; start_addr_i = j.addr; byte_count_i = j.cnt;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0 && busy_o == 1'b1, "R7 done cleared after start", done_o, 0);
    while (c < 3000) begin
      if (c < SETUP && (dev_rd_o || mem_we_o || !busy_o)) setup_bad++;
      if (mem_we_o) begin
        if (mem_addr_o != j.addr + 32'(wr)) aerr++;
        if (mem_data_o != pattern(idx, wr)) derr++;
        wr++;
      end
      if (done_o) begin
        done_c = c;
        irq_at_done = irq_o;
        break;
      end
      start_i = (j.intr_c != 0 && c == int'(j.intr_c));
      if (start_i) begin
        start_addr_i = 32'hDEAD_0000; byte_count_i = 16'd9;
      end
      if (dev_rd_o) begin
        if (j.stall_k != 0 && (rd % int'(j.stall_k)) == 0 && !stalled) begin
          dev_valid_i = 1'b0; stalled = 1'b1; stalls++;
        end else begin
          dev_valid_i = 1'b1; dev_data_i = pattern(idx, rd); stalled = 1'b0; rd++;
        end
      end else begin
        dev_valid_i = 1'b0;
        dev_data_i  = 8'hEE;
      end
      @(negedge clk);
      c++;
    end
    start_i = 1'b0;
    check(setup_bad == 0, "R1 setup silent", setup_bad, 0);
    check(aerr == 0, "R3 write addresses", aerr, 0);
    check(derr == 0, "R2 write data", derr, 0);
    check(wr == int'(j.cnt), (j.cnt == 0) ? "R5 write count" : "R4 write count", wr, j.cnt);
    check(done_c == SETUP + 2 * int'(j.cnt) + stalls,
          (j.cnt == 0) ? "R5 done cycle" : (stalls != 0) ? "R6 done cycle with stalls" :
          (j.intr_c != 0) ? "R8 done cycle with intruding start" : "R4 done cycle",
          done_c, SETUP + 2 * int'(j.cnt) + stalls);
    check(irq_at_done == 1'b1, "R7 irq with done", irq_at_done, 1);
    @(negedge clk);
    check(irq_o == 1'b0 && done_o == 1'b1, "R7 irq one cycle, done held", {irq_o, done_o}, 1);
    repeat (3) @(negedge clk);
    check(done_o == 1'b1 && busy_o == 1'b0, "R7 done held while idle", done_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_addr_i = '0; byte_count_i = '0;
    dev_valid_i = 1'b0; dev_data_i = '0;
    repeat (3) @(negedge clk);
    check({busy_o, done_o, irq_o, dev_rd_o, mem_we_o} == 5'b0, "R9 outputs in reset",
          {busy_o, done_o, irq_o, dev_rd_o, mem_we_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy_o, done_o, irq_o, dev_rd_o, mem_we_o} == 5'b0, "R9 idle after reset",
          {busy_o, done_o, irq_o, dev_rd_o, mem_we_o}, 0);
    for (int i = 0; i < 6; i++) run_job(i);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule